// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns one decoded load or store micro-operation into a memory request. It adds a base value to an offset and routes the result according to the indexing mode. The offset is either a sign-extended literal from the instruction or a second register value shifted left by a small amount. The mode then decides two things: whether the memory address is the sum or the untouched base, and whether the base register is rewritten with the sum. A single adder serves every mode. When the base index selects the program counter, the separately supplied PC value replaces the register value, which gives PC-relative addressing.

A request is taken into a one-entry slot through a valid/ready handshake. The slot drives the memory request until the memory accepts it. In the cycle after acceptance, the block presents two results side by side: the loaded data for its destination register, and the base writeback. Both can therefore retire together, and the base update costs no cycle of its own. An auto-update aimed at the program counter is blocked and reported through an error pulse.

Top module: `lsAddrGen`

## Requirements
- R1: With mode code 2'b00 (plain offset), the memory address is base + offset, and neither wbEn nor wbErr is raised for that operation.
- R2: With mode code 2'b01 (pre-update), the memory address is base + offset. In the cycle after the memory handshake, wbEn is high, wbIdx equals the base index and wbVal equals that same sum.
- R3: With mode code 2'b10 (post-update), the memory address is the unmodified base. In the cycle after the handshake, wbEn is high, wbIdx equals the base index and wbVal equals base + offset.
- R4: When reqOffIsReg is 0, the offset is reqImm taken as 12-bit two's complement (-2048 to 2047) and sign-extended to 32 bits.
- R5: When reqOffIsReg is 1, the offset is reqOffReg shifted left by reqShamt (0 to 31). Bits pushed past bit 31 are lost.
- R6: When reqBaseIdx is 15, the base is pcVal instead of reqBaseVal. In plain mode this causes no writeback.
- R7: An auto-update (code 2'b01 or 2'b10) whose base index is 15 never raises wbEn. Instead it raises wbErr for one cycle, in the cycle where wbEn would have risen.
- R8: While memValid is high and memReady is low, memAddr, memWe and memWdata hold their values, and reqReady stays low. wbEn and ldValid rise only in the cycle right after a cycle with memValid and memReady both high, and they last one cycle.
- R9: For a load (reqIsStore 0), memWe is low, and in the cycle after the handshake ldValid is high with ldIdx = reqDestIdx and ldData = the memRdata seen at the handshake, in the same cycle as any base writeback. For a store, memWe is high, memWdata equals reqStoreData and ldValid stays low.
- R10: Mode code 2'b11 behaves exactly like plain offset mode.
- R11: During and right after reset, memValid, wbEn, wbErr and ldValid are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request slot can take a request |
| reqMode | input | 2 | Indexing mode: 00 plain, 01 pre-update, 10 post-update, 11 plain |
| reqIsStore | input | 1 | 1 store, 0 load |
| reqBaseIdx | input | 4 | Base register index, 15 selects the PC |
| reqBaseVal | input | 32 | Base register value |
| pcVal | input | 32 | Program counter value used when the base index is 15 |
| reqOffIsReg | input | 1 | 0 literal offset, 1 register offset |
| reqImm | input | 12 | Signed literal offset |
| reqOffReg | input | 32 | Register offset value |
| reqShamt | input | 5 | Left shift applied to the register offset |
| reqStoreData | input | 32 | Data for a store |
| reqDestIdx | input | 4 | Destination register of a load |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Access address |
| memWe | output | 1 | Write enable |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the handshake cycle |
| ldValid | output | 1 | Load result valid |
| ldIdx | output | 4 | Load destination index |
| ldData | output | 32 | Load result |
| wbEn | output | 1 | Base writeback enable |
| wbIdx | output | 4 | Base writeback index |
| wbVal | output | 32 | Base writeback value |
| wbErr | output | 1 | Blocked writeback to the program counter |

## Verification
The assertions assume that the memory supplies read data in the same cycle that it raises memReady against a valid request. They also assume that request fields are only looked at while reqValid is high and reqReady answers. The bench keeps to these assumptions: it offers one request at a time and returns read data combinationally from the address. It holds memReady low for a random number of stall cycles before releasing it. Random requests draw every mode code, both offset sources, full-range literals and shift amounts, and they sometimes pick index 15, so that PC-relative access and blocked writebacks both occur.

// File: rtl/lsAddrGen_pkg.sv
package lsAddrGen_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_PRE   = 2'b01,
    MODE_POST  = 2'b10,
    MODE_ALT   = 2'b11
  } idxMode_e;

  typedef struct packed {
    logic capture;
    logic fire;
  } ctrlStrobe_t;

  function automatic logic modeUpdates(idxMode_e m);
    return (m == MODE_PRE) || (m == MODE_POST);
  endfunction

endpackage

// File: rtl/lsAddrGen_offset.sv
module lsAddrGen_offset #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic              offIsReg,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] offReg,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] offset
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] stage [0:SH_W];
  logic [DATA_W-1:0] immExt;

  assign stage[0] = offReg;

  // log-depth shifter: stage s shifts by 2**s when its shamt bit is set
  for (genvar s = 0; s < SH_W; s++) begin : g_shift
    assign stage[s+1] = shamt[s] ? (stage[s] << (2 ** s)) : stage[s];
  end

  assign immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign offset = offIsReg ? stage[SH_W] : immExt;

endmodule

// File: rtl/lsAddrGen_ctrl.sv
module lsAddrGen_ctrl
  import lsAddrGen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        memReady,
  output logic        slotValid,
  output ctrlStrobe_t strobe
);

  assign reqReady       = !slotValid || memReady;
  assign strobe.capture = reqValid && reqReady;
  assign strobe.fire    = slotValid && memReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= 1'b0;
    end else if (strobe.capture) begin
      slotValid <= 1'b1;
    end else if (strobe.fire) begin
      slotValid <= 1'b0;
    end
  end

  // a stalled request stays offered and blocks new ones
  assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !memReady) |=> (slotValid && !$past(reqReady)));

endmodule

// File: rtl/lsAddrGen_dpath.sv
module lsAddrGen_dpath
  import lsAddrGen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int IDX_W  = 4,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              slotValid,
  input  logic              memReady,
  input  logic [1:0]        reqMode,
  input  logic              reqIsStore,
  input  logic [IDX_W-1:0]  reqBaseIdx,
  input  logic [DATA_W-1:0] reqBaseVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic              reqOffIsReg,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic [DATA_W-1:0] reqOffReg,
  input  logic [SH_W-1:0]   reqShamt,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic [IDX_W-1:0]  reqDestIdx,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ldValid,
  output logic [IDX_W-1:0]  ldIdx,
  output logic [DATA_W-1:0] ldData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbVal,
  output logic              wbErr
);

  localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

  // captured request
  idxMode_e          slotMode;
  logic              slotStore;
  logic [IDX_W-1:0]  slotBaseIdx;
  logic [DATA_W-1:0] slotBase;
  logic              slotOffIsReg;
  logic [IMM_W-1:0]  slotImm;
  logic [DATA_W-1:0] slotOffReg;
  logic [SH_W-1:0]   slotShamt;
  logic [DATA_W-1:0] slotData;
  logic [IDX_W-1:0]  slotDest;

  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] sum;
  logic              wantWb;
  logic              hitsPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotMode     <= MODE_PLAIN;
      slotStore    <= 1'b0;
      slotBaseIdx  <= '0;
      slotBase     <= '0;
      slotOffIsReg <= 1'b0;
      slotImm      <= '0;
      slotOffReg   <= '0;
      slotShamt    <= '0;
      slotData     <= '0;
      slotDest     <= '0;
    end else if (strobe.capture) begin
      slotMode     <= idxMode_e'(reqMode);
      slotStore    <= reqIsStore;
      slotBaseIdx  <= reqBaseIdx;
      slotBase     <= (reqBaseIdx == PC_IDX) ? pcVal : reqBaseVal;
      slotOffIsReg <= reqOffIsReg;
      slotImm      <= reqImm;
      slotOffReg   <= reqOffReg;
      slotShamt    <= reqShamt;
      slotData     <= reqStoreData;
      slotDest     <= reqDestIdx;
    end
  end

  lsAddrGen_offset #(
    .DATA_W(DATA_W),
    .IMM_W (IMM_W),
    .SH_W  (SH_W)
  ) i_offset (
    .offIsReg(slotOffIsReg),
    .imm     (slotImm),
    .offReg  (slotOffReg),
    .shamt   (slotShamt),
    .offset  (offset)
  );

  // one adder: its sum is both the pre-update address and the new base
  assign sum      = slotBase + offset;
  assign memAddr  = (slotMode == MODE_POST) ? slotBase : sum;
  assign memWe    = slotStore;
  assign memWdata = slotData;

  assign wantWb = strobe.fire && modeUpdates(slotMode);
  assign hitsPc = (slotBaseIdx == PC_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldValid <= 1'b0;
      ldIdx   <= '0;
      ldData  <= '0;
      wbEn    <= 1'b0;
      wbIdx   <= '0;
      wbVal   <= '0;
      wbErr   <= 1'b0;
    end else begin
      ldValid <= strobe.fire && !slotStore;
      wbEn    <= wantWb && !hitsPc;
      wbErr   <= wantWb && hitsPc;
      if (strobe.fire) begin
        ldIdx  <= slotDest;
        ldData <= memRdata;
        wbIdx  <= slotBaseIdx;
        wbVal  <= sum;
      end
    end
  end

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !memReady) |=> ($stable(memAddr) && $stable(memWdata) && $stable(memWe)));

  assert_wb_after_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn || ldValid) |-> $past(strobe.fire));

  assert_no_pc_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbIdx != PC_IDX));

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wbEn && wbErr));

  assert_plain_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !modeUpdates(slotMode)) |=> (!wbEn && !wbErr));

  assert_pre_same_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && slotMode == MODE_PRE && !hitsPc) |=> (wbEn && wbVal == $past(memAddr)));

  assert_post_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && slotMode == MODE_POST && !hitsPc)
      |=> (wbEn && wbVal == $past(memAddr) + $past(offset)));

  assert_load_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !slotStore) |=> (ldValid && ldData == $past(memRdata)));

endmodule

// File: rtl/lsAddrGen.sv
module lsAddrGen
  import lsAddrGen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int IDX_W  = 4,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqMode,
  input  logic              reqIsStore,
  input  logic [IDX_W-1:0]  reqBaseIdx,
  input  logic [DATA_W-1:0] reqBaseVal,
  input  logic [DATA_W-1:0] pcVal,
  input  logic              reqOffIsReg,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic [DATA_W-1:0] reqOffReg,
  input  logic [SH_W-1:0]   reqShamt,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic [IDX_W-1:0]  reqDestIdx,
  output logic              memValid,
  input  logic              memReady,
  output logic [DATA_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              ldValid,
  output logic [IDX_W-1:0]  ldIdx,
  output logic [DATA_W-1:0] ldData,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbVal,
  output logic              wbErr
);

  ctrlStrobe_t strobe;
  logic        slotValid;

  lsAddrGen_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .memReady (memReady),
    .slotValid(slotValid),
    .strobe   (strobe)
  );

  lsAddrGen_dpath #(
    .DATA_W(DATA_W),
    .IMM_W (IMM_W),
    .IDX_W (IDX_W),
    .SH_W  (SH_W)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .slotValid   (slotValid),
    .memReady    (memReady),
    .reqMode     (reqMode),
    .reqIsStore  (reqIsStore),
    .reqBaseIdx  (reqBaseIdx),
    .reqBaseVal  (reqBaseVal),
    .pcVal       (pcVal),
    .reqOffIsReg (reqOffIsReg),
    .reqImm      (reqImm),
    .reqOffReg   (reqOffReg),
    .reqShamt    (reqShamt),
    .reqStoreData(reqStoreData),
    .reqDestIdx  (reqDestIdx),
    .memAddr     (memAddr),
    .memWe       (memWe),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .ldValid     (ldValid),
    .ldIdx       (ldIdx),
    .ldData      (ldData),
    .wbEn        (wbEn),
    .wbIdx       (wbIdx),
    .wbVal       (wbVal),
    .wbErr       (wbErr)
  );

  assign memValid = slotValid;

  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!memValid && !wbEn && !wbErr && !ldValid));

endmodule

// File: tb/test_lsAddrGen.sv
module test_lsAddrGen;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqMode = 2'b00;
  logic        reqIsStore = 1'b0;
  logic [3:0]  reqBaseIdx = 4'd0;
  logic [31:0] reqBaseVal = '0;
  logic [31:0] pcVal = '0;
  logic        reqOffIsReg = 1'b0;
  logic [11:0] reqImm = '0;
  logic [31:0] reqOffReg = '0;
  logic [4:0]  reqShamt = '0;
  logic [31:0] reqStoreData = '0;
  logic [3:0]  reqDestIdx = '0;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [31:0] memAddr;
  logic        memWe;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        ldValid;
  logic [3:0]  ldIdx;
  logic [31:0] ldData;
  logic        wbEn;
  logic [3:0]  wbIdx;
  logic [31:0] wbVal;
  logic        wbErr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdata = memAddr ^ 32'h5A5A_0F0F;

  lsAddrGen i_lsAddrGen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqIsStore(reqIsStore), .reqBaseIdx(reqBaseIdx),
    .reqBaseVal(reqBaseVal), .pcVal(pcVal), .reqOffIsReg(reqOffIsReg),
    .reqImm(reqImm), .reqOffReg(reqOffReg), .reqShamt(reqShamt),
    .reqStoreData(reqStoreData), .reqDestIdx(reqDestIdx),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .ldValid(ldValid), .ldIdx(ldIdx), .ldData(ldData),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbVal(wbVal), .wbErr(wbErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expOffset(logic isReg, logic [11:0] imm,
                                            logic [31:0] r, logic [4:0] sh);
    logic [31:0] ext;
    ext = {{20{imm[11]}}, imm};
    return isReg ? (r << sh) : ext;
  endfunction

  // one complete operation: offer, stall, handshake, retire
  task automatic runOp(input logic [1:0] mode, input logic isStore, input logic [3:0] bIdx,
                       input logic [31:0] bVal, input logic isReg, input logic [11:0] imm,
                       input logic [31:0] oReg, input logic [4:0] sh, input logic [31:0] sData,
                       input logic [3:0] dIdx, input int stalls, input string tag);
    logic [31:0] base, off, sum, addr;
    logic        upd;
    base = (bIdx == 4'd15) ? pcVal : bVal;
    off  = expOffset(isReg, imm, oReg, sh);
    sum  = base + off;
    addr = (mode == 2'b10) ? base : sum;
    upd  = (mode == 2'b01) || (mode == 2'b10);
    @(negedge clk);
    check({tag, " R8 idle ready"}, {31'd0, reqReady}, 32'd1);
    reqMode = mode; reqIsStore = isStore; reqBaseIdx = bIdx; reqBaseVal = bVal;
    reqOffIsReg = isReg; reqImm = imm; reqOffReg = oReg; reqShamt = sh;
    reqStoreData = sData; reqDestIdx = dIdx; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqBaseVal = ~bVal; reqOffReg = ~oReg; reqImm = ~imm; reqStoreData = ~sData;
    check({tag, " memValid"}, {31'd0, memValid}, 32'd1);
    check({tag, " R1 R2 R3 memAddr"}, memAddr, addr);
    check({tag, " R9 memWe"}, {31'd0, memWe}, {31'd0, isStore});
    if (isStore) check({tag, " R9 memWdata"}, memWdata, sData);
    for (int s = 0; s < stalls; s++) begin
      @(negedge clk);
      check({tag, " R8 stall addr"}, memAddr, addr);
      check({tag, " R8 stall valid"}, {31'd0, memValid}, 32'd1);
      check({tag, " R8 stall ready"}, {31'd0, reqReady}, 32'd0);
      check({tag, " R8 no early wb"}, {30'd0, wbEn, ldValid}, 32'd0);
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    check({tag, " R8 drained"}, {31'd0, memValid}, 32'd0);
    check({tag, " R9 ldValid"}, {31'd0, ldValid}, {31'd0, !isStore});
    if (!isStore) begin
      check({tag, " R9 ldIdx"}, {28'd0, ldIdx}, {28'd0, dIdx});
      check({tag, " R9 ldData"}, ldData, addr ^ 32'h5A5A_0F0F);
    end
    check({tag, " R1 R7 wbEn"}, {31'd0, wbEn}, {31'd0, upd && bIdx != 4'd15});
    check({tag, " R6 R7 wbErr"}, {31'd0, wbErr}, {31'd0, upd && bIdx == 4'd15});
    if (upd && bIdx != 4'd15) begin
      check({tag, " R2 R3 wbIdx"}, {28'd0, wbIdx}, {28'd0, bIdx});
      check({tag, " R2 R3 wbVal"}, wbVal, sum);
    end
    @(negedge clk);
    check({tag, " R8 pulse ends"}, {29'd0, wbEn, wbErr, ldValid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    pcVal = 32'h0000_8000;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 memValid", {31'd0, memValid}, 32'd0);
    check("R11 outputs", {29'd0, wbEn, wbErr, ldValid}, 32'd0);
    check("R11 reqReady", {31'd0, reqReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 after release", {30'd0, memValid, wbEn}, 32'd0);

    runOp(2'b00, 1'b0, 4'd1, 32'h0000_1000, 1'b0, 12'd32,  '0, 5'd0, '0, 4'd2, 0, "R1 plain lit");
    runOp(2'b00, 1'b0, 4'd1, 32'h0000_1000, 1'b0, 12'h800, '0, 5'd0, '0, 4'd3, 1, "R4 min lit");
    runOp(2'b00, 1'b1, 4'd2, 32'h0000_1000, 1'b0, 12'h7FF, '0, 5'd0, 32'hDEAD_BEEF, 4'd0, 0, "R4 max lit store");
    runOp(2'b00, 1'b0, 4'd0, 32'h0000_2000, 1'b1, 12'd0, 32'd5, 5'd2, '0, 4'd4, 0, "R5 reg lsl2 plain");
    runOp(2'b00, 1'b0, 4'd0, 32'h0000_0000, 1'b1, 12'd0, 32'h0000_0003, 5'd31, '0, 4'd4, 0, "R5 shift drop");
    runOp(2'b01, 1'b0, 4'd1, 32'h0000_1000, 1'b0, 12'd8, '0, 5'd0, '0, 4'd5, 2, "R2 pre lit");
    runOp(2'b01, 1'b1, 4'd3, 32'h0000_4000, 1'b1, 12'd0, 32'd7, 5'd3, 32'h1234_5678, 4'd0, 0, "R2 pre reg store");
    runOp(2'b10, 1'b0, 4'd1, 32'h0000_1000, 1'b0, 12'd8, '0, 5'd0, '0, 4'd6, 0, "R3 post lit");
    runOp(2'b10, 1'b0, 4'd7, 32'h0000_0100, 1'b0, 12'hFFC, '0, 5'd0, '0, 4'd6, 3, "R3 post neg");
    runOp(2'b00, 1'b0, 4'd15, 32'hFFFF_0000, 1'b0, 12'd24, '0, 5'd0, '0, 4'd8, 0, "R6 pc plain");
    runOp(2'b01, 1'b0, 4'd15, 32'hFFFF_0000, 1'b0, 12'd4, '0, 5'd0, '0, 4'd8, 0, "R7 pc pre");
    runOp(2'b10, 1'b1, 4'd15, 32'hFFFF_0000, 1'b0, 12'd4, '0, 5'd0, 32'h0BAD_F00D, 4'd8, 1, "R7 pc post");
    runOp(2'b11, 1'b0, 4'd9, 32'h0000_3000, 1'b0, 12'd16, '0, 5'd0, '0, 4'd1, 0, "R10 alt mode");
    runOp(2'b11, 1'b0, 4'd9, 32'h0000_3000, 1'b1, 12'd0, 32'd9, 5'd4, '0, 4'd1, 0, "R10 alt reg");

    for (int n = 0; n < N_RANDOM; n++) begin
      logic [3:0] bi;
      bi = ($urandom_range(0, 7) == 0) ? 4'd15 : 4'($urandom_range(0, 14));
      pcVal = $urandom;
      runOp(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), bi, $urandom,
            1'($urandom_range(0, 1)), 12'($urandom), $urandom, 5'($urandom),
            $urandom, 4'($urandom), $urandom_range(0, 2), "random R1 R2 R3 R4 R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule